// File: doc/BRIEF.md
# Staggered Four-Channel Threshold Trigger

The block watches four 10-bit sample streams, one per channel, and decides on each strobe whether each sample lies strictly above that channel's own threshold. The four yes/no results are not sent out as parallel wires. Instead they are serialised onto a single trigger line. Each channel gets one clock period of its own, at a fixed offset from the strobe. At 20 MHz one period is 50 ns, so channel 0 appears first and the others follow 50, 100 and 150 ns later. A receiver that counts periods from the first slot can tell which channel fired.

A host programs the thresholds through a small register bus. Each channel's threshold has an address equal to its channel index. A write takes effect from the next strobe, and reads return the stored value at once. After reset every threshold holds all ones. No sample can exceed that value, so the line stays quiet until software has programmed a channel.

A two-state machine controls the sequence. In `ST_IDLE` the line is low and the machine waits. The transition ACCEPT fires on a strobe: it captures all four compare results and enters `ST_SLOT` at slot 0. While in `ST_SLOT`, ADVANCE moves to the next slot each clock. FINISH returns to `ST_IDLE` after the last slot. Strobes that arrive while the machine is in `ST_SLOT` are dropped.

Top module: `stagger_trig`

## Requirements
- R1: Each of the four channels has its own 10-bit threshold register. The host writes channel c's register with `reg_we_i` high, `reg_addr_i` = c (0 to 3) and the value on `reg_wdata_i`; the register updates at that clock edge.
- R2: `reg_rdata_o` shows, in the same cycle and without a clock edge, the threshold stored at `reg_addr_i`.
- R3: After reset all thresholds read 1023 (all ones), `trig_o` is low and the sequencer is idle. A strobe with every sample at 1023 therefore produces no pulse.
- R4: Channel c hits when its sample (bits [10c+9:10c] of `sample_i`) is strictly greater than its threshold. A sample equal to the threshold does not hit. Samples are compared at the clock edge where a strobe is accepted.
- R5: After an accepting edge, `trig_o` carries channel c's hit during the (c+1)-th clock period. Channel 0 comes in the first period, channel 3 in the fourth. Each contribution is exactly one clock period wide.
- R6: The sequencer accepts a strobe only when idle. A strobe that is high during any of the four slot periods is ignored and starts no sequence. The earliest next acceptance is the edge that follows the last slot period.
- R7: If a threshold write and an accepted strobe fall on the same edge, that compare uses the old threshold. The new value applies from the next strobe onwards.
- R8: `trig_o` is low whenever the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (20 MHz in the application) |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 40 | Four packed samples, channel c in bits [10c+9:10c] |
| strobe_i | input | 1 | Requests a compare and a slot sequence |
| reg_we_i | input | 1 | Threshold write enable |
| reg_addr_i | input | 2 | Threshold register select (channel index) |
| reg_wdata_i | input | 10 | Threshold write value |
| reg_rdata_o | output | 10 | Threshold stored at `reg_addr_i` |
| trig_o | output | 1 | Time-multiplexed trigger line |

## Verification
Two of the block's functions can meet in one cycle: a threshold write and an accepted strobe on the same edge. The bench provokes this by writing channel 2's threshold above the shared sample value in the very cycle that raises the strobe. It judges the result in two steps. First, the sequence that follows must still show channel 2 firing, because that compare used the old value. Second, an identical strobe afterwards must leave channel 2's slot empty. A second overlap is a strobe held high across the running slots. Here the bench checks that the pulses of the first sequence are unchanged and that no new sequence follows.

// File: rtl/stagger_trig_pkg.sv
package stagger_trig_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SLOT = 1'b1
    } seq_state_t;

endpackage

// File: rtl/thr_regfile.sv
module thr_regfile #(
    parameter int N_CHAN   = 4,
    parameter int SAMPLE_W = 10,
    localparam int AW      = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [SAMPLE_W-1:0]        wdata,
    output logic [SAMPLE_W-1:0]        rdata,
    output logic [N_CHAN*SAMPLE_W-1:0] thr_flat
);

    logic [SAMPLE_W-1:0] thr_q [N_CHAN];

    for (genvar c = 0; c < N_CHAN; c++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thr_q[c] <= '1;
            end else if (we && (addr == AW'(c))) begin
                thr_q[c] <= wdata;
            end
        end
        assign thr_flat[c*SAMPLE_W +: SAMPLE_W] = thr_q[c];
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < N_CHAN; c++) begin
            if (addr == AW'(c)) begin
                rdata = thr_q[c];
            end
        end
    end

endmodule

// File: rtl/chan_compare.sv
module chan_compare #(
    parameter int N_CHAN   = 4,
    parameter int SAMPLE_W = 10
) (
    input  logic [N_CHAN*SAMPLE_W-1:0] sample_flat,
    input  logic [N_CHAN*SAMPLE_W-1:0] thr_flat,
    output logic [N_CHAN-1:0]          hit
);

    for (genvar c = 0; c < N_CHAN; c++) begin : g_cmp
        assign hit[c] = sample_flat[c*SAMPLE_W +: SAMPLE_W] > thr_flat[c*SAMPLE_W +: SAMPLE_W];
    end

endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import stagger_trig_pkg::*;
#(
    parameter int N_CHAN = 4,
    localparam int SW    = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
    localparam logic [SW-1:0] LAST = SW'(N_CHAN - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [N_CHAN-1:0] hit_in,
    output logic              trig,
    output logic              busy
);

    seq_state_t        state_q, state_d;
    logic [SW-1:0]     slot_q, slot_d;
    logic [N_CHAN-1:0] hits_q, hits_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            hits_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            hits_q  <= hits_d;
        end
    end

    // transitions: WAIT, ACCEPT, ADVANCE, FINISH
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        hits_d  = hits_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe) begin
                    state_d = ST_SLOT;
                    slot_d  = '0;
                    hits_d  = hit_in;
                end
            end
            ST_SLOT: begin
                if (slot_q == LAST) begin
                    state_d = ST_IDLE;
                    slot_d  = '0;
                end else begin
                    slot_d  = slot_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_SLOT);
        trig = busy && hits_q[slot_q];
    end

endmodule

// File: rtl/stagger_trig.sv
module stagger_trig #(
    parameter int N_CHAN   = 4,
    parameter int SAMPLE_W = 10,
    localparam int AW      = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CHAN*SAMPLE_W-1:0] sample_i,
    input  logic                       strobe_i,
    input  logic                       reg_we_i,
    input  logic [AW-1:0]              reg_addr_i,
    input  logic [SAMPLE_W-1:0]        reg_wdata_i,
    output logic [SAMPLE_W-1:0]        reg_rdata_o,
    output logic                       trig_o
);

    logic [N_CHAN*SAMPLE_W-1:0] thr_flat;
    logic [N_CHAN-1:0]          hit_vec;
    logic                       seq_busy;

    thr_regfile #(.N_CHAN(N_CHAN), .SAMPLE_W(SAMPLE_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .rdata    (reg_rdata_o),
        .thr_flat (thr_flat)
    );

    chan_compare #(.N_CHAN(N_CHAN), .SAMPLE_W(SAMPLE_W)) cmp_i (
        .sample_flat (sample_i),
        .thr_flat    (thr_flat),
        .hit         (hit_vec)
    );

    slot_sequencer #(.N_CHAN(N_CHAN)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe_i),
        .hit_in (hit_vec),
        .trig   (trig_o),
        .busy   (seq_busy)
    );

endmodule

// File: rtl/stagger_trig_chk.sv
module stagger_trig_chk #(
    parameter int N_CHAN   = 4,
    parameter int SAMPLE_W = 10,
    localparam int AW      = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
    localparam int CW      = $clog2(N_CHAN + 1) + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                strobe_i,
    input logic                reg_we_i,
    input logic [AW-1:0]       reg_addr_i,
    input logic [SAMPLE_W-1:0] reg_wdata_i,
    input logic [SAMPLE_W-1:0] reg_rdata_o,
    input logic                trig_o,
    input logic                busy
);

    logic [CW-1:0] run_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) run_len_q <= '0;
        else        run_len_q <= busy ? run_len_q + 1'b1 : '0;
    end

    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_i |=> (reg_addr_i != $past(reg_addr_i)) || (reg_rdata_o == $past(reg_wdata_i)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we_i |=> (reg_addr_i != $past(reg_addr_i)) || $stable(reg_rdata_o));

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && strobe_i) |=> busy);

    p_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len_q < CW'(N_CHAN)));

    p_full_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len_q == CW'(N_CHAN)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !trig_o);

endmodule

bind stagger_trig stagger_trig_chk #(.N_CHAN(N_CHAN), .SAMPLE_W(SAMPLE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (strobe_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .trig_o      (trig_o),
    .busy        (seq_busy)
);

// File: tb/stagger_trig_tb_top.sv
module stagger_trig_tb_top;

    localparam int NC = 4;
    localparam int W  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC*W-1:0] sample_i = '0;
    logic          strobe_i = 1'b0;
    logic          reg_we_i = 1'b0;
    logic [1:0]    reg_addr_i = '0;
    logic [W-1:0]  reg_wdata_i = '0;
    logic [W-1:0]  reg_rdata_o;
    logic          trig_o;

    int checks = 0;
    int errors = 0;
    int thr_m [NC];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stagger_trig dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample_i),
        .strobe_i    (strobe_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .trig_o      (trig_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_thr(input int c, input int v);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = 2'(c); reg_wdata_i = W'(v);
        @(negedge clk);
        reg_we_i = 1'b0;
        thr_m[c] = v;
    endtask

    task automatic read_chk(input int c, input string req);
        reg_addr_i = 2'(c);
        #1;
        check(req, int'(reg_rdata_o), thr_m[c]);
    endtask

    // R4 R5: strobe, then check each slot and the idle cycle after
    task automatic fire(input int s0, input int s1, input int s2, input int s3);
        int s [NC];
        bit exp [NC];
        s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            sample_i[c*W +: W] = W'(s[c]);
            exp[c] = (s[c] > thr_m[c]);
        end
        strobe_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
        for (int k = 0; k < NC; k++) begin
            check($sformatf("R4/R5 slot %0d", k), int'(trig_o), int'(exp[k]));
            @(negedge clk);
        end
        check("R8 idle after slots", int'(trig_o), 0);
    endtask

    function automatic int clampv(input int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int vals [8];
        vals = '{0, 1, 2, 100, 511, 900, 1022, 1023};
        for (int c = 0; c < NC; c++) thr_m[c] = 1023;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        check("R3 trig after reset", int'(trig_o), 0);
        for (int c = 0; c < NC; c++) read_chk(c, "R3 threshold reset value");
        fire(1023, 1023, 1023, 1023);

        // R1 R2 R4 R5: sweep of thresholds and boundary samples
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < NC; c++) write_thr(c, vals[(i + c) % 8]);
            for (int c = 0; c < NC; c++) read_chk(c, "R1/R2 readback");
            for (int d = 0; d < 3; d++) begin
                fire(clampv(thr_m[0] + (d + 0) % 3 - 1), clampv(thr_m[1] + (d + 1) % 3 - 1),
                     clampv(thr_m[2] + (d + 2) % 3 - 1), clampv(thr_m[3] + d % 3 - 1));
            end
        end

        // R5: every hit pattern
        for (int c = 0; c < NC; c++) write_thr(c, 500);
        for (int p = 0; p < 16; p++) begin
            fire(p[0] ? 501 : 500, p[1] ? 501 : 500, p[2] ? 501 : 500, p[3] ? 501 : 500);
        end

        // R6: strobe during running slots ignored
        @(negedge clk);
        sample_i = {W'(501), W'(500), W'(501), W'(500)};
        strobe_i = 1'b1;
        @(negedge clk);
        check("R6 slot0 first run", int'(trig_o), 0);
        sample_i = {W'(600), W'(600), W'(600), W'(600)};
        @(negedge clk);
        check("R6 slot1 first run", int'(trig_o), 1);
        @(negedge clk);
        check("R6 slot2 first run", int'(trig_o), 0);
        @(negedge clk);
        check("R6 slot3 first run", int'(trig_o), 1);
        strobe_i = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R6 no sequence from ignored strobe", int'(trig_o), 0);
        end

        // R6: back-to-back strobe accepted right after the last slot
        fire(600, 400, 400, 400);
        fire(400, 400, 400, 600);

        // R7: write on the same edge as an accepted strobe
        @(negedge clk);
        sample_i = {W'(600), W'(600), W'(600), W'(600)};
        strobe_i = 1'b1;
        reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = W'(700);
        @(negedge clk);
        strobe_i = 1'b0;
        reg_we_i = 1'b0;
        for (int k = 0; k < NC; k++) begin
            check("R7 old threshold used", int'(trig_o), 1);
            @(negedge clk);
        end
        thr_m[2] = 700;
        read_chk(2, "R7 new threshold stored");
        fire(600, 600, 600, 600);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule